// File: doc/BRIEF.md
# Pushbutton Input Port with Release Capture

This block is a small register-mapped input port for four active-low pushbuttons. The raw button lines are brought into the clock domain through a two-stage synchronizer. After that point a pressed button reads as 1. The port reports the current pressed set one-hot. It also keeps a sticky capture flag per button, and that flag is set when the button goes from pressed to released.

Software reaches three registers over a simple word-addressed bus that has an address, a write strobe, write data and combinational read data:

- **Live button state** at word 0, read-only.
- **Interrupt enable mask** at word 2, which is byte offset 0x8.
- **Capture flags** at word 3, which is byte offset 0xC. A flag is cleared by writing a 1 to its bit, so writing back the value just read works.

A level interrupt request stays high while any captured button is also enabled in the mask.

Top module: `btn_port`

## Requirements
- R1: Button i maps to bit i, so button 0 is 0x1 and button 3 is 0x8. Buttons are active low: a 0 on btn_n_i[i] means pressed. Reading word address 0 returns 1 for each pressed button. The value reflects the input after two synchronizing flops.
- R2: Word address 2 (byte 0x8) holds the interrupt enable mask in bits [3:0]. A 1 enables a button and a 0 disables it, and the register reads back what was written.
- R3: Word address 3 (byte 0xC) holds the capture flags in bits [3:0]. A flag is set one cycle after the synchronized button goes from pressed to released. Pressing alone does not set it.
- R4: A capture flag stays set, through further presses and idle time, until software clears it.
- R5: A write to word address 3 clears each capture flag whose write-data bit is 1. Flags whose bit is 0 are unchanged, so writing 0xF clears all flags.
- R6: If a release and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R7: irq_o is high while (capture & mask) is nonzero, and low otherwise.
- R8: Bits above bit 3 always read 0, and word address 1 reads 0. Writes to word address 0 change nothing.
- R9: Synchronous active-high reset clears the mask, the capture flags and the synchronizer state, so irq_o is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n_i | input | 4 | Raw active-low button lines |
| bus_addr_i | input | 2 | Word address of the register |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational on address) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: four buttons and a 32-bit data word. With four buttons, a short table can cover single-button, multi-button and all-button patterns against masks that fully overlap, partly overlap or are disjoint. That is enough to exercise both levels of the interrupt. The 32-bit word puts 28 unused upper bits within reach. The bench writes ones into them to show they are discarded and read back as zero. The bench times one release so that it lands on the same edge as a clearing write, which tests the set-wins rule.

// File: rtl/btnport_pkg.sv
package btnport_pkg;

    localparam int unsigned BP_ADDR_W = 2;
    localparam int unsigned BP_DATA_W = 32;
    localparam int unsigned BP_NUM_BTN = 4;

    typedef enum logic [BP_ADDR_W-1:0] {
        SLOT_LEVEL = 2'd0,
        SLOT_SPARE = 2'd1,
        SLOT_MASK  = 2'd2,
        SLOT_CAPT  = 2'd3
    } slot_e;

    typedef struct packed {
        logic level;
        logic mask;
        logic capt;
    } slot_sel_t;

    function automatic slot_sel_t slot_decode(input logic [BP_ADDR_W-1:0] a);
        slot_sel_t s;
        s.level = (a == SLOT_LEVEL);
        s.mask  = (a == SLOT_MASK);
        s.capt  = (a == SLOT_CAPT);
        return s;
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int unsigned NUM_BTN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BTN-1:0] btn_n_i,
    output logic [NUM_BTN-1:0] pressed_o
);

    logic [NUM_BTN-1:0] stage_a;
    logic [NUM_BTN-1:0] stage_b;

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_a[g] <= 1'b0;
                stage_b[g] <= 1'b0;
            end else begin
                stage_a[g] <= ~btn_n_i[g];
                stage_b[g] <= stage_a[g];
            end
        end
    end

    assign pressed_o = stage_b;

    // R1: pressed state follows the inverted raw line two edges later
    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (pressed_o == ~$past(btn_n_i, 2)));

endmodule

// File: rtl/btn_release_cap.sv
module btn_release_cap #(
    parameter int unsigned NUM_BTN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BTN-1:0] pressed_i,
    input  logic               clr_we_i,
    input  logic [NUM_BTN-1:0] clr_bits_i,
    output logic [NUM_BTN-1:0] capt_o
);

    logic [NUM_BTN-1:0] pressed_q;
    logic [NUM_BTN-1:0] rel;
    logic [NUM_BTN-1:0] clr_eff;
    logic [NUM_BTN-1:0] capt_q;
    logic [NUM_BTN-1:0] capt_d;

    always_ff @(posedge clk) begin
        if (rst) pressed_q <= '0;
        else     pressed_q <= pressed_i;
    end

    assign rel     = pressed_q & ~pressed_i;
    assign clr_eff = clr_we_i ? clr_bits_i : '0;

    always_comb begin
        for (int i = 0; i < NUM_BTN; i++) begin
            // release has priority over a clear in the same cycle
            capt_d[i] = rel[i] | (capt_q[i] & ~clr_eff[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) capt_q <= '0;
        else     capt_q <= capt_d;
    end

    assign capt_o = capt_q;

    // R3, R6: every release lands in the capture register, even under a clear
    assert_release_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (|rel) |=> ((capt_q & $past(rel)) == $past(rel)));

    // R3: a flag never rises without a release in the previous cycle
    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (rst)
        ((capt_q & ~$past(capt_q) & ~$past(rel)) == '0));

    // R5: cleared bits drop when no release coincides
    assert_clear_works_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_we_i && ((rel & clr_bits_i) == '0)) |=> ((capt_q & $past(clr_bits_i)) == '0));

    // R4: without a clear, set flags hold
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_we_i |=> ((capt_q & $past(capt_q)) == $past(capt_q)));

endmodule

// File: rtl/btn_mask_reg.sv
module btn_mask_reg #(
    parameter int unsigned NUM_BTN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we_i,
    input  logic [NUM_BTN-1:0] wbits_i,
    output logic [NUM_BTN-1:0] mask_o
);

    logic [NUM_BTN-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (we_i) mask_q <= wbits_i;
    end

    assign mask_o = mask_q;

    // R2: a write is visible the next cycle; otherwise the mask holds
    assert_mask_write_R2: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mask_o == $past(wbits_i)));
    assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(mask_o));

endmodule

// File: rtl/btn_port.sv
module btn_port
    import btnport_pkg::*;
#(
    parameter int unsigned NUM_BTN = BP_NUM_BTN,
    parameter int unsigned DATA_W  = BP_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BTN-1:0]   btn_n_i,
    input  logic [BP_ADDR_W-1:0] bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_BTN;

    slot_sel_t          sel;
    logic [NUM_BTN-1:0] pressed;
    logic [NUM_BTN-1:0] mask;
    logic [NUM_BTN-1:0] capt;

    assign sel = slot_decode(bus_addr_i);

    btn_sync #(.NUM_BTN(NUM_BTN)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .btn_n_i   (btn_n_i),
        .pressed_o (pressed)
    );

    btn_mask_reg #(.NUM_BTN(NUM_BTN)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (bus_we_i & sel.mask),
        .wbits_i (bus_wdata_i[NUM_BTN-1:0]),
        .mask_o  (mask)
    );

    btn_release_cap #(.NUM_BTN(NUM_BTN)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .pressed_i  (pressed),
        .clr_we_i   (bus_we_i & sel.capt),
        .clr_bits_i (bus_wdata_i[NUM_BTN-1:0]),
        .capt_o     (capt)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (sel.level)     bus_rdata_o = {{PAD_W{1'b0}}, pressed};
        else if (sel.mask) bus_rdata_o = {{PAD_W{1'b0}}, mask};
        else if (sel.capt) bus_rdata_o = {{PAD_W{1'b0}}, capt};
    end

    assign irq_o = |(capt & mask);

    // R8: upper read bits are always zero
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata_o[DATA_W-1:NUM_BTN] == '0));

    // R7: interrupt cannot appear while the mask is empty
    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq_o);

endmodule

// File: tb/btn_port_tb_top.sv
module btn_port_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  btn_n;
    logic [1:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    btn_port dut_i (
        .clk         (clk),
        .rst         (rst),
        .btn_n_i     (btn_n),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {pattern[3:0], mask[3:0], expected irq}
    localparam logic [8:0] VEC [0:7] = '{
        {4'b0001, 4'b0001, 1'b1},
        {4'b0010, 4'b0001, 1'b0},
        {4'b0100, 4'b1111, 1'b1},
        {4'b1000, 4'b0111, 1'b0},
        {4'b1010, 4'b1000, 1'b1},
        {4'b0101, 4'b1010, 1'b0},
        {4'b1111, 4'b0000, 1'b0},
        {4'b0110, 4'b0100, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; btn_n = 4'hF; addr = 2'd0; we = 1'b0; wdata = '0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R9: reset state
        bus_read(2'd2, r); check("R9 mask after reset", r, 0);
        bus_read(2'd3, r); check("R9 capture after reset", r, 0);
        bus_read(2'd0, r); check("R9 data after reset", r, 0);
        check("R9 irq after reset", {31'd0, irq}, 0);

        // table walk: R1, R2, R3, R7
        for (int k = 0; k < 8; k++) begin
            logic [3:0] pat;
            logic [3:0] msk;
            pat = VEC[k][8:5];
            msk = VEC[k][4:1];
            bus_write(2'd3, 32'hF);
            bus_write(2'd2, {28'd0, msk});
            btn_n = ~pat;
            tick(4);
            bus_read(2'd0, r); check("R1 pressed one-hot", r, {28'd0, pat});
            bus_read(2'd3, r); check("R3 press alone no capture", r, 0);
            btn_n = 4'hF;
            tick(4);
            bus_read(2'd3, r); check("R3 capture after release", r, {28'd0, pat});
            bus_read(2'd2, r); check("R2 mask readback", r, {28'd0, msk});
            check("R7 irq level", {31'd0, irq}, {31'd0, VEC[k][0]});
        end

        // R4: sticky through idle time and another press
        bus_write(2'd3, 32'hF);
        bus_write(2'd2, 32'h0);
        btn_n = 4'b1101; tick(4); btn_n = 4'hF; tick(4);
        tick(20);
        btn_n = 4'b1101; tick(4);
        bus_read(2'd3, r); check("R4 sticky while pressed again", r, 32'h2);
        btn_n = 4'hF; tick(4);

        // R5: partial clear
        btn_n = 4'h0; tick(4); btn_n = 4'hF; tick(4);
        bus_write(2'd3, 32'h5);
        bus_read(2'd3, r); check("R5 partial clear", r, 32'hA);
        bus_write(2'd3, 32'hF);
        bus_read(2'd3, r); check("R5 clear all", r, 32'h0);

        // R7: irq drops when captures cleared and rises on mask enable
        btn_n = 4'b0111; tick(4); btn_n = 4'hF; tick(4);
        check("R7 irq low with mask zero", {31'd0, irq}, 0);
        bus_write(2'd2, 32'h8);
        check("R7 irq high after enable", {31'd0, irq}, 1);
        bus_write(2'd3, 32'h8);
        check("R7 irq low after clear", {31'd0, irq}, 0);

        // R6: release coincides with clearing write
        bus_write(2'd3, 32'hF);
        btn_n = 4'b1101; tick(4); btn_n = 4'hF; tick(4);   // capture bit1
        btn_n = 4'b1110; tick(4);                         // bit0 held
        btn_n = 4'hF;                                     // release at this negedge
        @(negedge clk);
        @(negedge clk);
        bus_write(2'd3, 32'h3);                           // strobe on release edge
        bus_read(2'd3, r); check("R6 set wins over clear", r, 32'h1);

        // R8: unused word, upper bits, writes to data word
        bus_write(2'd3, 32'hF);
        bus_write(2'd2, 32'h5);
        bus_read(2'd1, r); check("R8 unused word reads zero", r, 0);
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read(2'd0, r); check("R8 data write ignored", r, 0);
        bus_read(2'd2, r); check("R8 data write leaves mask", r, 32'h5);
        bus_write(2'd2, 32'hFFFF_FFF0);
        bus_read(2'd2, r); check("R8 mask upper bits zero", r, 0);

        // R9: reset mid-run
        bus_write(2'd2, 32'hF);
        btn_n = 4'b1011; tick(4); btn_n = 4'hF; tick(4);
        check("R9 irq before reset", {31'd0, irq}, 1);
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        bus_read(2'd2, r); check("R9 mask cleared", r, 0);
        bus_read(2'd3, r); check("R9 capture cleared", r, 0);
        check("R9 irq cleared", {31'd0, irq}, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule